// File: doc/BRIEF.md
# Receive Descriptor List Walker

This block follows a singly linked chain of fixed-size receive descriptors held in host memory on behalf of a packet receive path. When the receive path wants to begin a packet, it strobes a start request. The walker decides whether a free descriptor is available and answers with a one-cycle grant or a one-cycle refusal. Once a granted packet has been accepted, the receive path strobes accept together with five status words. The walker writes those words into the current descriptor, reads that descriptor's link word, and then does one of two things. If the link points onward, the walker moves to the next descriptor and claims it by writing zero into its in-use word. If the link marks the end of the list, the walker stays where it is, remembers where the link word sits, and raises a sticky exhausted flag for the host.

The host can extend the list at any time by rewriting the final link word. On the next start request after an end-of-list, the walker reads that same link word again before it decides. All memory traffic goes through a single word-wide master port with a request/acknowledge handshake. Only one access is outstanding at a time.

Each descriptor occupies seven consecutive words. Words 0 to 4 hold status, word 5 holds the link and word 6 holds the in-use flag. In the link word, bit 0 is the end-of-list flag, and the remaining bits give the next descriptor's word address with bit 0 forced to zero. The parameter DW must be at least AW.

Top module: `rx_desc_walker`

## Requirements
- R1: After reset, busy_o, exhausted_o, mem_req_o, rx_grant_o and rx_refuse_o are all 0, and the current descriptor is at word address HEAD.
- R2: A start request, made while the stored end-of-list flag is 0 and the exhausted flag is clear, produces rx_grant_o one cycle later and makes no memory access.
- R3: A start request, made while the stored end-of-list flag is 1 and the exhausted flag is clear, reads the saved link-word address (old descriptor + 5). If bit 0 of the word read is 1, rx_refuse_o pulses and the exhausted flag is not changed. If bit 0 is 0, the current descriptor becomes the word read with bit 0 cleared, and rx_grant_o pulses.
- R4: An accept that follows a grant writes the five status words, word k of rx_status_i (bits k*DW upward), to descriptor address + k in the order k = 0 to 4, and then reads descriptor address + 5.
- R5: If the link word read in R4 has bit 0 equal to 0, the current descriptor becomes that word with bit 0 cleared, and the value 0 is written to new descriptor + 6.
- R6: If the link word read in R4 has bit 0 equal to 1, the current descriptor is unchanged, no in-use word is written, and exhausted_o is set.
- R7: exhausted_o stays at 1 until irq_clear_i is high at a clock edge. While it is 1, a start request is refused with no memory access.
- R8: mem_req_o, once raised, stays high with mem_addr_o, mem_we_o and mem_wdata_o unchanged until the cycle in which mem_ack_i is high. Only one access is issued per acknowledge.
- R9: busy_o rises in the cycle after an accepted rx_accept_i and falls after the acknowledge of the final write-back access. No grant is issued while busy_o is high.
- R10: rx_accept_i is ignored when no grant is pending, and both strobes are ignored while a walk or re-read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_start_i | input | 1 | Receive path asks to begin a packet |
| rx_accept_i | input | 1 | Receive path accepted the granted packet |
| rx_status_i | input | 5*DW | Five status words, word k at bits k*DW upward |
| irq_clear_i | input | 1 | Host clears the exhausted flag |
| rx_grant_o | output | 1 | One-cycle pulse: packet may be received |
| rx_refuse_o | output | 1 | One-cycle pulse: no descriptor available |
| busy_o | output | 1 | Write-back in progress |
| exhausted_o | output | 1 | Sticky list-exhausted interrupt |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Word address |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, valid with mem_ack_i |
| mem_ack_i | input | 1 | Access complete |

## Verification
The bench builds the walker with AW = 8, DW = 16 and HEAD = 0x10, so a 128-word memory model holds the whole descriptor chain. Every address the walker produces is then a direct index into that model. This lets the bench read each status, link and in-use word straight from the model. It can confirm that the final descriptor's in-use word keeps its preset value, and it can append to the list by rewriting the tail link word between start requests.

// File: rtl/rdw_pkg.sv
package rdw_pkg;

    localparam int STAT_WORDS = 5;
    localparam int OFS_LINK   = 5;
    localparam int OFS_INUSE  = 6;
    localparam int DESC_WORDS = 7;

    typedef enum logic [2:0] {
        WK_IDLE,
        WK_RECHK,
        WK_STAT,
        WK_LINK,
        WK_INUSE
    } walk_state_e;

    typedef struct packed {
        logic go;
        logic refuse;
    } start_res_t;

    function automatic logic is_mem_state(input walk_state_e s);
        return (s == WK_RECHK) || (s == WK_STAT) || (s == WK_LINK) || (s == WK_INUSE);
    endfunction

    function automatic logic is_write_state(input walk_state_e s);
        return (s == WK_STAT) || (s == WK_INUSE);
    endfunction

endpackage

// File: rtl/rdw_stat_bank.sv
module rdw_stat_bank #(
    parameter int DW = 32,
    parameter int N  = 5,
    localparam int SW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cap_i,
    input  logic [N*DW-1:0] words_i,
    input  logic [SW-1:0]   sel_i,
    output logic [DW-1:0]   word_o
);

    logic [DW-1:0] held [N];

    for (genvar g = 0; g < N; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                held[g] <= '0;
            else if (cap_i)
                held[g] <= words_i[g*DW +: DW];
        end
    end

    always_comb begin
        word_o = '0;
        for (int k = 0; k < N; k++)
            if (sel_i == SW'(k))
                word_o = held[k];
    end

endmodule

// File: rtl/rdw_ptr.sv
module rdw_ptr
    import rdw_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter logic [AW-1:0] HEAD = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv_i,
    input  logic          mark_end_i,
    input  logic          clr_i,
    input  logic [DW-1:0] link_i,
    output logic [AW-1:0] cur_o,
    output logic [AW-1:0] link_addr_o,
    output logic          eol_o,
    output logic          exh_o
);

    logic [AW-1:0] cur_q;
    logic [AW-1:0] lnk_q;
    logic          eol_q;
    logic          exh_q;
    logic [AW-1:0] next_base;

    assign next_base = {link_i[AW-1:1], 1'b0};

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= HEAD;
            lnk_q <= HEAD + AW'(OFS_LINK);
            eol_q <= 1'b0;
            exh_q <= 1'b0;
        end else begin
            if (adv_i) begin
                cur_q <= next_base;
                eol_q <= 1'b0;
            end
            if (mark_end_i) begin
                eol_q <= 1'b1;
                lnk_q <= cur_q + AW'(OFS_LINK);
                exh_q <= 1'b1;
            end else if (clr_i) begin
                exh_q <= 1'b0;
            end
        end
    end

    assign cur_o       = cur_q;
    assign link_addr_o = lnk_q;
    assign eol_o       = eol_q;
    assign exh_o       = exh_q;

endmodule

// File: rtl/rdw_seq.sv
module rdw_seq
    import rdw_pkg::*;
#(
    parameter int AW = 32,
    localparam int SW = $clog2(STAT_WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          accept_i,
    input  logic          exh_i,
    input  logic          eol_i,
    input  logic [AW-1:0] cur_i,
    input  logic [AW-1:0] link_addr_i,
    input  logic          ack_i,
    input  logic          rd_eol_i,
    output logic [SW-1:0] idx_o,
    output logic          cap_o,
    output logic          adv_o,
    output logic          mark_end_o,
    output logic          busy_o,
    output logic          grant_o,
    output logic          refuse_o,
    output logic          req_o,
    output logic          we_o,
    output logic          zero_o,
    output logic [AW-1:0] addr_o
);

    walk_state_e state_q;
    logic [SW-1:0] idx_q;
    logic          pend_q;
    start_res_t    res_q;
    start_res_t    res_d;

    assign cap_o      = (state_q == WK_IDLE) && !start_i && accept_i && pend_q;
    assign adv_o      = ack_i && !rd_eol_i && ((state_q == WK_RECHK) || (state_q == WK_LINK));
    assign mark_end_o = ack_i && rd_eol_i && (state_q == WK_LINK);

    always_comb begin
        res_d = '0;
        if (state_q == WK_IDLE && start_i) begin
            if (exh_i)
                res_d.refuse = 1'b1;
            else if (!eol_i)
                res_d.go = 1'b1;
        end else if (state_q == WK_RECHK && ack_i) begin
            res_d.go     = !rd_eol_i;
            res_d.refuse = rd_eol_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WK_IDLE;
            idx_q   <= '0;
            pend_q  <= 1'b0;
            res_q   <= '0;
        end else begin
            res_q <= res_d;
            if (res_d.go)
                pend_q <= 1'b1;
            case (state_q)
                WK_IDLE: begin
                    if (start_i) begin
                        if (!exh_i && eol_i)
                            state_q <= WK_RECHK;
                    end else if (cap_o) begin
                        pend_q  <= 1'b0;
                        idx_q   <= '0;
                        state_q <= WK_STAT;
                    end
                end
                WK_RECHK: begin
                    if (ack_i)
                        state_q <= WK_IDLE;
                end
                WK_STAT: begin
                    if (ack_i) begin
                        if (idx_q == SW'(STAT_WORDS - 1))
                            state_q <= WK_LINK;
                        else
                            idx_q <= idx_q + 1'b1;
                    end
                end
                WK_LINK: begin
                    if (ack_i)
                        state_q <= rd_eol_i ? WK_IDLE : WK_INUSE;
                end
                WK_INUSE: begin
                    if (ack_i)
                        state_q <= WK_IDLE;
                end
                default: state_q <= WK_IDLE;
            endcase
        end
    end

    always_comb begin
        case (state_q)
            WK_RECHK: addr_o = link_addr_i;
            WK_STAT:  addr_o = cur_i + AW'(idx_q);
            WK_LINK:  addr_o = cur_i + AW'(OFS_LINK);
            WK_INUSE: addr_o = cur_i + AW'(OFS_INUSE);
            default:  addr_o = cur_i;
        endcase
    end

    assign req_o    = is_mem_state(state_q);
    assign we_o     = is_write_state(state_q);
    assign zero_o   = (state_q == WK_INUSE);
    assign busy_o   = (state_q == WK_STAT) || (state_q == WK_LINK) || (state_q == WK_INUSE);
    assign grant_o  = res_q.go;
    assign refuse_o = res_q.refuse;
    assign idx_o    = idx_q;

endmodule

// File: rtl/rx_desc_walker.sv
module rx_desc_walker
    import rdw_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter logic [AW-1:0] HEAD = '0,
    localparam int SW = $clog2(STAT_WORDS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     rx_start_i,
    input  logic                     rx_accept_i,
    input  logic [STAT_WORDS*DW-1:0] rx_status_i,
    input  logic                     irq_clear_i,
    output logic                     rx_grant_o,
    output logic                     rx_refuse_o,
    output logic                     busy_o,
    output logic                     exhausted_o,
    output logic                     mem_req_o,
    output logic                     mem_we_o,
    output logic [AW-1:0]            mem_addr_o,
    output logic [DW-1:0]            mem_wdata_o,
    input  logic [DW-1:0]            mem_rdata_i,
    input  logic                     mem_ack_i
);

    logic [SW-1:0] idx;
    logic          cap;
    logic          adv;
    logic          mark_end;
    logic          zero_wr;
    logic [AW-1:0] cur;
    logic [AW-1:0] link_addr;
    logic          eol;
    logic          exh;
    logic [DW-1:0] stat_word;

    rdw_stat_bank #(.DW(DW), .N(STAT_WORDS)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .cap_i   (cap),
        .words_i (rx_status_i),
        .sel_i   (idx),
        .word_o  (stat_word)
    );

    rdw_ptr #(.AW(AW), .DW(DW), .HEAD(HEAD)) u_ptr (
        .clk         (clk),
        .rst         (rst),
        .adv_i       (adv),
        .mark_end_i  (mark_end),
        .clr_i       (irq_clear_i),
        .link_i      (mem_rdata_i),
        .cur_o       (cur),
        .link_addr_o (link_addr),
        .eol_o       (eol),
        .exh_o       (exh)
    );

    rdw_seq #(.AW(AW)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_i     (rx_start_i),
        .accept_i    (rx_accept_i),
        .exh_i       (exh),
        .eol_i       (eol),
        .cur_i       (cur),
        .link_addr_i (link_addr),
        .ack_i       (mem_ack_i),
        .rd_eol_i    (mem_rdata_i[0]),
        .idx_o       (idx),
        .cap_o       (cap),
        .adv_o       (adv),
        .mark_end_o  (mark_end),
        .busy_o      (busy_o),
        .grant_o     (rx_grant_o),
        .refuse_o    (rx_refuse_o),
        .req_o       (mem_req_o),
        .we_o        (mem_we_o),
        .zero_o      (zero_wr),
        .addr_o      (mem_addr_o)
    );

    assign mem_wdata_o = zero_wr ? '0 : stat_word;
    assign exhausted_o = exh;

endmodule

// File: rtl/rx_desc_walker_chk.sv
module rx_desc_walker_chk #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          irq_clear_i,
    input logic          rx_grant_o,
    input logic          rx_refuse_o,
    input logic          busy_o,
    input logic          exhausted_o,
    input logic          mem_req_o,
    input logic          mem_we_o,
    input logic [AW-1:0] mem_addr_o,
    input logic [DW-1:0] mem_wdata_o,
    input logic          mem_ack_i
);

    assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)
                                       && $stable(mem_we_o) && $stable(mem_wdata_o)));

    assert_exh_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (exhausted_o && !irq_clear_i) |=> exhausted_o);

    assert_no_grant_when_exh_R7: assert property (@(posedge clk) disable iff (rst)
        rx_grant_o |-> !exhausted_o);

    assert_exh_from_walk_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(exhausted_o) |-> $past(busy_o));

    assert_busy_ends_on_ack_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> $past(mem_ack_i));

    assert_no_grant_busy_R9: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> !rx_grant_o);

    assert_one_answer_R2: assert property (@(posedge clk) disable iff (rst)
        !(rx_grant_o && rx_refuse_o));

    assert_busy_writes_R4: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !mem_req_o) |-> 1'b0 == 1'b1 || !busy_o);

endmodule

bind rx_desc_walker rx_desc_walker_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .irq_clear_i (irq_clear_i),
    .rx_grant_o  (rx_grant_o),
    .rx_refuse_o (rx_refuse_o),
    .busy_o      (busy_o),
    .exhausted_o (exhausted_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ack_i   (mem_ack_i)
);

// File: tb/rx_desc_walker_tb.sv
module rx_desc_walker_tb;

    localparam int AW = 8;
    localparam int DW = 16;
    localparam int NW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rx_start = 1'b0;
    logic          rx_accept = 1'b0;
    logic [NW*DW-1:0] rx_status = '0;
    logic          irq_clear = 1'b0;
    logic          grant, refuse, busy, exh;
    logic          req, we, ack;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;

    logic [DW-1:0] mem [128];
    logic          host_we = 1'b0;
    logic [6:0]    host_a = '0;
    logic [DW-1:0] host_d = '0;
    int            acc_cnt;
    int            checks = 0;
    int            fails = 0;

    always #4 clk = ~clk;

    rx_desc_walker #(.AW(AW), .DW(DW), .HEAD(8'h10)) u_dut (
        .clk(clk), .rst(rst), .rx_start_i(rx_start), .rx_accept_i(rx_accept),
        .rx_status_i(rx_status), .irq_clear_i(irq_clear),
        .rx_grant_o(grant), .rx_refuse_o(refuse), .busy_o(busy), .exhausted_o(exh),
        .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata),
        .mem_rdata_i(rdata), .mem_ack_i(ack)
    );

    always @(posedge clk) begin
        if (rst) begin
            ack     <= 1'b0;
            rdata   <= '0;
            acc_cnt <= 0;
            for (int i = 0; i < 128; i++) mem[i] <= 16'hFFFF;
        end else begin
            ack <= req && !ack;
            if (req && !ack) begin
                acc_cnt <= acc_cnt + 1;
                if (we) mem[addr[6:0]] <= wdata;
                else    rdata <= mem[addr[6:0]];
            end
            if (host_we) mem[host_a] <= host_d;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [6:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        host_we = 1'b1; host_a = a; host_d = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    function automatic logic [DW-1:0] sval(input logic [7:0] base, input int k);
        return {base, 4'hC, 4'(k)};
    endfunction

    // returns 1 for grant, 0 for refuse, 2 for no answer
    task automatic do_start(output int res);
        res = 2;
        @(negedge clk);
        rx_start = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            rx_start = 1'b0;
            if (grant)  begin res = 1; break; end
            if (refuse) begin res = 0; break; end
        end
    endtask

    task automatic do_accept(input logic [7:0] base, input string tag);
        @(negedge clk);
        for (int k = 0; k < NW; k++) rx_status[k*DW +: DW] = sval(base, k);
        rx_accept = 1'b1;
        @(negedge clk);
        rx_accept = 1'b0;
        check({tag, " R9 busy after accept"}, int'(busy), 1);
        for (int i = 0; i < 100; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
        check({tag, " R9 busy falls"}, int'(busy), 0);
    endtask

    localparam logic [7:0] TB_BASE [3] = '{8'h10, 8'h20, 8'h30};
    localparam logic [7:0] TB_NEXT [3] = '{8'h20, 8'h30, 8'h40};
    localparam logic       TB_EXH  [3] = '{1'b0, 1'b0, 1'b1};

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int res;
        int c0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", int'(busy), 0);
        check("R1 exhausted", int'(exh), 0);
        check("R1 req", int'(req), 0);
        check("R1 pulses", int'(grant | refuse), 0);

        poke(7'h15, 16'h0020);
        poke(7'h25, 16'h0030);
        poke(7'h35, 16'h0041);

        // R10 accept with no pending grant is ignored
        @(negedge clk); rx_accept = 1'b1;
        @(negedge clk); rx_accept = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 busy stays low", int'(busy), 0);
        check("R10 no memory access", acc_cnt, 0);

        for (int v = 0; v < 3; v++) begin
            c0 = acc_cnt;
            do_start(res);
            check("R2 grant", res, 1);
            check("R2 no access on start", acc_cnt - c0, 0);
            do_accept(TB_BASE[v], "loop");
            for (int k = 0; k < NW; k++)
                check("R4 status word", int'(mem[TB_BASE[v][6:0] + 7'(k)]), int'(sval(TB_BASE[v], k)));
            if (TB_EXH[v]) begin
                check("R6 in-use untouched", int'(mem[TB_NEXT[v][6:0] + 7'd6]), 16'hFFFF);
                check("R6 access count", acc_cnt - c0, 6);
            end else begin
                check("R5 in-use cleared", int'(mem[TB_NEXT[v][6:0] + 7'd6]), 0);
                check("R5 access count", acc_cnt - c0, 7);
            end
            check("R6 exhausted flag", int'(exh), int'(TB_EXH[v]));
        end

        // R7 exhausted set: refused, no memory access
        c0 = acc_cnt;
        do_start(res);
        check("R7 refuse while exhausted", res, 0);
        check("R7 no access", acc_cnt - c0, 0);
        repeat (4) @(negedge clk);
        check("R7 still sticky", int'(exh), 1);
        @(negedge clk); irq_clear = 1'b1;
        @(negedge clk); irq_clear = 1'b0;
        check("R7 cleared", int'(exh), 0);

        // R3 re-read with list still ended
        c0 = acc_cnt;
        do_start(res);
        check("R3 refuse after re-read", res, 0);
        check("R3 one re-read access", acc_cnt - c0, 1);
        check("R3 exhausted unchanged", int'(exh), 0);

        // R3 host appends a descriptor, re-read picks it up
        poke(7'h35, 16'h0040);
        poke(7'h45, 16'h0051);
        c0 = acc_cnt;
        do_start(res);
        check("R3 grant after append", res, 1);
        check("R3 one access", acc_cnt - c0, 1);

        // R10 start ignored while busy
        @(negedge clk);
        for (int k = 0; k < NW; k++) rx_status[k*DW +: DW] = sval(8'h40, k);
        rx_accept = 1'b1;
        @(negedge clk);
        rx_accept = 1'b0;
        rx_start = 1'b1;
        @(negedge clk);
        rx_start = 1'b0;
        @(negedge clk);
        check("R10 no answer while busy", int'(grant | refuse), 0);
        for (int i = 0; i < 100; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
        for (int k = 0; k < NW; k++)
            check("R3 status at new descriptor", int'(mem[7'h40 + 7'(k)]), int'(sval(8'h40, k)));
        check("R6 in-use of tail untouched", int'(mem[7'h56]), 16'hFFFF);
        check("R6 exhausted after append walk", int'(exh), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule